// File: doc/BRIEF.md
# Three-Channel DAC Code Register Front End

This block sits between a parallel processor-style write bus and the digital inputs of a three-channel 8-bit voltage converter. The bus provides an 8-bit data word, a 2-bit address and an active-low write strobe. Three of the four address codes each select one channel code register. The fourth address has no register behind it and acts as a command to power the analog side down. Each channel code is driven out continuously to the converter core.

The block samples the strobe, address and data on the system clock. On every rising edge where the strobe is low, the addressed channel register takes the bus value, so a strobe held low for several cycles makes the register track the bus. A write to the power-down address raises an output-disable flag, which the analog stage uses to tri-state its outputs. The next write to any channel address clears that flag. A settle counter then holds the ready flag low for a fixed number of clock cycles, covering the 13 µs the outputs need to recover. The channel codes are cleared only by reset, and they are unaffected by power-down and wake-up.

Top module: `tri_dac_front`

## Requirements
- R1: Address code 0 selects channel A (`code_a`), code 1 selects channel B (`code_b`) and code 2 selects channel C (`code_c`).
- R2: On each rising clock edge with `wr_n` low and a channel address, the addressed register loads `data`, and the new value is visible after that edge. Holding `wr_n` low over several edges makes the register follow the bus. With `wr_n` high, all registers hold their values.
- R3: While `rst_n` is low, all three codes are 0x00, `out_disable` is 0 and `out_ready` is 1.
- R4: A rising edge with `wr_n` low and address 3 sets `out_disable` to 1 and `out_ready` to 0 after that edge.
- R5: A write to address 3 leaves all three channel codes unchanged.
- R6: While `out_disable` is 1, a write to a channel address clears `out_disable` after that edge. The same write also loads that channel's register.
- R7: Channel codes keep their values through power-down and wake-up, and they are shown on the code outputs while `out_disable` is 1.
- R8: After a wake-up edge, `out_ready` stays 0 for SETTLE_CYCLES-1 further edges and becomes 1 after the SETTLE_CYCLES-th edge. `out_ready` is never 1 while `out_disable` is 1.
- R9: A power-down write during settling cancels the countdown, including one that arrives on the very edge where `out_ready` would have risen. The next wake-up starts a full count of SETTLE_CYCLES.
- R10: A channel write changes only the addressed register, and the other two hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_n | input | 1 | Active-low write strobe, sampled on the clock |
| addr | input | 2 | Channel select (0 to 2); 3 is the power-down command |
| data | input | 8 | Write data bus |
| code_a | output | 8 | Channel A code to the converter core |
| code_b | output | 8 | Channel B code to the converter core |
| code_c | output | 8 | Channel C code to the converter core |
| out_disable | output | 1 | Tells the analog stage to tri-state its outputs |
| out_ready | output | 1 | High when the outputs have settled |

## Verification
A single channel write during power-down does two things on one edge: it loads a code and it wakes the block. The bench issues such a write and checks, at the next sample point, both the new code and the cleared disable flag. Two other functions can also fall on one edge: the settle countdown finishing, and a fresh power-down command. The bench times an address-3 write to land exactly on the edge where `out_ready` would rise, and then requires `out_ready` to stay low, `out_disable` to be high, and the following wake-up to take a full SETTLE_CYCLES count again.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int CODE_W  = 8;
    localparam int N_CH    = 3;
    localparam int ADDR_W  = 2;
    localparam logic [ADDR_W-1:0] SD_ADDR = ADDR_W'(3);

    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/dacif_decode.sv
module dacif_decode
    import dacif_pkg::*;
(
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_CH-1:0]   ch_sel,
    output logic              sd_hit,
    output logic              ch_hit
);
    for (genvar i = 0; i < N_CH; i++) begin : g_sel
        assign ch_sel[i] = !wr_n && (addr == ADDR_W'(i));
    end

    assign sd_hit = !wr_n && (addr == SD_ADDR);
    assign ch_hit = |ch_sel;
endmodule

// File: rtl/dacif_chan_reg.sv
module dacif_chan_reg
    import dacif_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  code_t data,
    output code_t code
);
    code_t code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (load) begin
            code_d = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code = code_q;
endmodule

// File: rtl/dacif_power.sv
module dacif_power #(
    parameter int SETTLE_CYCLES = 3250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sd_hit,
    input  logic ch_hit,
    output logic disable_o,
    output logic ready_o
);
    localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        logic             sd;
        logic             rdy;
        logic [CNT_W-1:0] cnt;
    } pwr_t;

    pwr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sd_hit) begin
            st_d.sd  = 1'b1;
            st_d.rdy = 1'b0;
            st_d.cnt = '0;
        end else if (ch_hit && st_q.sd) begin
            st_d.sd  = 1'b0;
            st_d.rdy = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.sd && !st_q.rdy) begin
            if (st_q.cnt == LAST) begin
                st_d.rdy = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sd: 1'b0, rdy: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign disable_o = st_q.sd;
    assign ready_o   = st_q.rdy;
endmodule

// File: rtl/tri_dac_front.sv
module tri_dac_front
    import dacif_pkg::*;
#(
    parameter int SETTLE_CYCLES = 3250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] data,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic [CODE_W-1:0] code_c,
    output logic              out_disable,
    output logic              out_ready
);
    logic [N_CH-1:0] ch_sel;
    logic            sd_hit;
    logic            ch_hit;
    code_t           codes [N_CH];

    dacif_decode i_decode (
        .wr_n   (wr_n),
        .addr   (addr),
        .ch_sel (ch_sel),
        .sd_hit (sd_hit),
        .ch_hit (ch_hit)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        dacif_chan_reg i_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (ch_sel[i]),
            .data  (data),
            .code  (codes[i])
        );
    end

    dacif_power #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .sd_hit    (sd_hit),
        .ch_hit    (ch_hit),
        .disable_o (out_disable),
        .ready_o   (out_ready)
    );

    assign code_a = codes[0];
    assign code_b = codes[1];
    assign code_c = codes[2];
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker #(
    parameter int SETTLE_CYCLES = 3250
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] data,
    input logic [7:0] code_a,
    input logic [7:0] code_b,
    input logic [7:0] code_c,
    input logic       out_disable,
    input logic       out_ready
);
    logic [31:0] since_wake;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_wake <= '0;
        end else if (out_disable) begin
            since_wake <= '0;
        end else if (!out_ready && since_wake != 32'hFFFF_FFFF) begin
            since_wake <= since_wake + 1;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> ($stable(code_a) && $stable(code_b) && $stable(code_c)));

    p_load_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && addr == 2'd0) |=> (code_a == $past(data) && $stable(code_b) && $stable(code_c)));

    p_load_c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && addr == 2'd2) |=> (code_c == $past(data) && $stable(code_a) && $stable(code_b)));

    p_sd_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && addr == 2'd3) |=> ($stable(code_a) && $stable(code_b) && $stable(code_c)));

    p_sd_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && addr == 2'd3) |=> (out_disable && !out_ready));

    p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_disable && !wr_n && addr != 2'd3) |=> !out_disable);

    p_dis_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_disable |-> !out_ready);

    p_settle_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_ready) |-> (since_wake == SETTLE_CYCLES));
endmodule

bind tri_dac_front dacif_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_dacif_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_n        (wr_n),
    .addr        (addr),
    .data        (data),
    .code_a      (code_a),
    .code_b      (code_b),
    .code_c      (code_c),
    .out_disable (out_disable),
    .out_ready   (out_ready)
);

// File: tb/test_tri_dac_front.sv
`timescale 1ns/1ps
module test_tri_dac_front;
    localparam int SETTLE = 3250;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] data = '0;
    logic [7:0] code_a, code_b, code_c;
    logic       out_disable, out_ready;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    tri_dac_front #(.SETTLE_CYCLES(SETTLE)) i_tri_dac_front (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .data(data),
        .code_a(code_a), .code_b(code_b), .code_c(code_c),
        .out_disable(out_disable), .out_ready(out_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_codes(input string req, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        chk({req, " code_a"}, 32'(code_a), 32'(a));
        chk({req, " code_b"}, 32'(code_b), 32'(b));
        chk({req, " code_c"}, 32'(code_c), 32'(c));
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        wr_n = 1'b0; addr = a; data = d;
        @(negedge clk);
        wr_n = 1'b1;
    endtask

    task automatic t_reset;
        chk_codes("R3 reset", 8'h00, 8'h00, 8'h00);
        chk("R3 reset disable", 32'(out_disable), 0);
        chk("R3 reset ready", 32'(out_ready), 1);
    endtask

    task automatic t_map;
        bus_write(2'd0, 8'h11);
        chk_codes("R1 write A", 8'h11, 8'h00, 8'h00);
        bus_write(2'd1, 8'h22);
        chk_codes("R1 write B", 8'h11, 8'h22, 8'h00);
        bus_write(2'd2, 8'h33);
        chk_codes("R10 write C", 8'h11, 8'h22, 8'h33);
        bus_write(2'd1, 8'hFF);
        chk_codes("R10 rewrite B", 8'h11, 8'hFF, 8'h33);
    endtask

    task automatic t_follow_hold;
        wr_n = 1'b0; addr = 2'd2; data = 8'h40;
        @(negedge clk);
        chk("R2 follow 1", 32'(code_c), 32'h40);
        data = 8'h41;
        @(negedge clk);
        chk("R2 follow 2", 32'(code_c), 32'h41);
        addr = 2'd0; data = 8'hA5;
        @(negedge clk);
        chk_codes("R2 follow addr change", 8'hA5, 8'hFF, 8'h41);
        wr_n = 1'b1; data = 8'h5A; addr = 2'd1;
        repeat (3) @(negedge clk);
        chk_codes("R2 hold strobe high", 8'hA5, 8'hFF, 8'h41);
    endtask

    task automatic t_shutdown;
        bus_write(2'd3, 8'h99);
        chk("R4 disable set", 32'(out_disable), 1);
        chk("R4 ready clear", 32'(out_ready), 0);
        chk_codes("R5 codes after sd write", 8'hA5, 8'hFF, 8'h41);
        repeat (5) @(negedge clk);
        chk_codes("R7 codes in shutdown", 8'hA5, 8'hFF, 8'h41);
        chk("R4 still disabled", 32'(out_disable), 1);
    endtask

    task automatic t_wake_settle;
        bus_write(2'd1, 8'h7E);
        chk("R6 disable cleared", 32'(out_disable), 0);
        chk_codes("R6 wake loads B, R7 retained", 8'hA5, 8'h7E, 8'h41);
        chk("R8 ready low at wake", 32'(out_ready), 0);
        repeat (SETTLE - 1) @(negedge clk);
        chk("R8 ready low one before", 32'(out_ready), 0);
        @(negedge clk);
        chk("R8 ready high at count", 32'(out_ready), 1);
    endtask

    task automatic t_cancel;
        bus_write(2'd3, 8'h00);
        bus_write(2'd0, 8'h12);
        repeat (SETTLE - 1) @(negedge clk);
        chk("R9 ready low before collision", 32'(out_ready), 0);
        bus_write(2'd3, 8'hEE);
        chk("R9 sd wins ready", 32'(out_ready), 0);
        chk("R9 sd wins disable", 32'(out_disable), 1);
        chk_codes("R9 codes kept", 8'h12, 8'h7E, 8'h41);
        bus_write(2'd2, 8'h56);
        repeat (SETTLE - 1) @(negedge clk);
        chk("R9 full recount low", 32'(out_ready), 0);
        @(negedge clk);
        chk("R9 full recount high", 32'(out_ready), 1);
        chk_codes("R9 final codes", 8'h12, 8'h7E, 8'h56);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_map;
        t_follow_hold;
        t_shutdown;
        t_wake_settle;
        t_cancel;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule